// File: doc/BRIEF.md
# Thermal Trip Latch Controller

This block guards a die against overheating. It takes digital junction-temperature codes from an on-chip sensor. When an accepted code is at or above a fixed trip code, it latches a trip. The latched trip drives an active-low alarm pin and a request to stop the internal clocks. The alarm pin is modelled as an open-drain output: a separate enable says when the pin is actively driven, and the data level stays inactive whenever that enable is low.

Two release schemes are chosen by a static mode input. In reset-release mode the pin is always driven, and only the block reset clears a latched trip. In power-window mode the pin is driven only inside a power-good window. That window opens after a bounded number of microsecond ticks following the rise of power-good, and it closes at once when power-good falls. The fall of power-good also clears the latch. In both schemes, a die that is still hot trips again on the first hot code accepted after the release.

Temperature codes arrive on a valid/ready stream. The block never applies back-pressure: ready is held high, and a code is accepted in every cycle where valid is high. Codes offered with valid low are ignored.

Top module: `thermal_trip_ctrl`

## Requirements
- R1: During and directly after reset, trip_n is 1 and halt_req is 0. trip_oe is 1 when release_mode is 0 (reset-release) and 0 when release_mode is 1 (power-window).
- R2: An accepted code (temp_valid=1) with temp_code >= TRIP_CODE (default 135) while armed latches a trip. From the next cycle halt_req is 1, and trip_n is 0 whenever trip_oe is 1.
- R3: A code below TRIP_CODE, or any code offered with temp_valid=0, does not set a trip.
- R4: Once latched, a trip stays set through any later codes until its release event.
- R5: In reset-release mode only reset clears the trip. A hot code accepted after reset trips again.
- R6: In reset-release mode trip_oe is 1 out of reset, and pwr_ok has no effect on trip_oe, trip_n or the latch.
- R7: In power-window mode trip_oe becomes 1 in the cycle after the clock edge that sees the EN_DELAY_US-th us_tick since pwr_ok rose (default 10). It is 0 before that.
- R8: In power-window mode trip_oe is 0 and trip_n is 1 in the same cycle that pwr_ok is 0. The latch is cleared at the next clock edge.
- R9: In power-window mode a hot code accepted while pwr_ok is 1, but before the window opens, sets halt_req. trip_n goes low once trip_oe rises.
- R10: temp_ready is 1 in every cycle out of reset.
- R11: In power-window mode, reset also clears a latched trip.
- R12: In power-window mode a hot code offered in a cycle with pwr_ok at 0 is not latched. The release wins over the set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good, synchronous to clk |
| release_mode | input | 1 | 0 = reset-release, 1 = power-window; static after reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| temp_valid | input | 1 | Temperature code valid |
| temp_ready | output | 1 | Always high: no back-pressure |
| temp_code | input | CODE_W | Junction temperature code, degrees C |
| trip_n | output | 1 | Active-low thermal trip level |
| trip_oe | output | 1 | Drive enable for trip_n (open-drain model) |
| halt_req | output | 1 | Request to stop the internal clocks |

## Verification
Two functions can meet in the same cycle: the window-opening tick and a hot code, or the power-good fall and a hot code. The bench provokes the first by offering a hot code on the same edge as the final us_tick. In that case trip_oe and a low trip_n must both appear in the very next cycle. It provokes the second by offering a hot code in the cycle where pwr_ok drops. In that case halt_req must stay low, and after power returns no trip may appear until a new hot code is accepted.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
  typedef enum logic {
    REL_ON_RESET = 1'b0,
    REL_ON_PWROK = 1'b1
  } rel_mode_e;
endpackage

// File: rtl/tt_temp_compare.sv
module tt_temp_compare #(
  parameter int CODE_W    = 8,
  parameter int TRIP_CODE = 135
) (
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic              hot_seen
);
  localparam logic [CODE_W-1:0] TRIP_VAL = CODE_W'(TRIP_CODE);

  // a code counts only on an accepted beat
  always_comb hot_seen = valid && (code >= TRIP_VAL);
endmodule

// File: rtl/tt_drive_window.sv
module tt_drive_window #(
  parameter int EN_DELAY_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic us_tick,
  output logic window_open
);
  localparam int CW = $clog2(EN_DELAY_US + 1);
  localparam logic [CW-1:0] LAST = CW'(EN_DELAY_US - 1);

  logic [CW-1:0] cnt_q;
  logic          open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (!pwr_ok) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (!open_q && us_tick) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) open_q <= 1'b1;
    end
  end

  // window shuts in the same cycle power-good falls
  always_comb window_open = open_q && pwr_ok;

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(EN_DELAY_US));
  p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !open_q);
  p_open_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(us_tick));
endmodule

// File: rtl/tt_trip_latch.sv
module tt_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic release_now,
  input  logic hot_seen,
  output logic tripped
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tripped <= 1'b0;
    else if (release_now)        tripped <= 1'b0;
    else if (armed && hot_seen)  tripped <= 1'b1;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hot_seen && !release_now) |=> tripped);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !release_now) |=> tripped);
  p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> !tripped);
endmodule

// File: rtl/thermal_trip_ctrl.sv
module thermal_trip_ctrl
  import thermtrip_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int TRIP_CODE   = 135,
  parameter int EN_DELAY_US = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              release_mode,
  input  logic              us_tick,
  input  logic              temp_valid,
  output logic              temp_ready,
  input  logic [CODE_W-1:0] temp_code,
  output logic              trip_n,
  output logic              trip_oe,
  output logic              halt_req
);
  rel_mode_e mode;
  logic hot_seen, window_open, tripped;
  logic armed, release_now, drive_en;

  always_comb mode = rel_mode_e'(release_mode);

  tt_temp_compare #(.CODE_W(CODE_W), .TRIP_CODE(TRIP_CODE)) u_cmp (
    .valid(temp_valid), .code(temp_code), .hot_seen(hot_seen));

  tt_drive_window #(.EN_DELAY_US(EN_DELAY_US)) u_win (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .us_tick(us_tick),
    .window_open(window_open));

  always_comb begin
    if (mode == REL_ON_PWROK) begin
      armed       = pwr_ok;
      release_now = !pwr_ok;
      drive_en    = window_open;
    end else begin
      armed       = 1'b1;
      release_now = 1'b0;
      drive_en    = 1'b1;
    end
  end

  tt_trip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .armed(armed), .release_now(release_now),
    .hot_seen(hot_seen), .tripped(tripped));

  assign temp_ready = 1'b1;
  assign trip_oe    = drive_en;
  assign trip_n     = !(tripped && drive_en);
  assign halt_req   = tripped;

  p_pin_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> halt_req);
  p_idle_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_oe |-> trip_n);
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_mode && !pwr_ok) |-> (trip_n && !trip_oe));
  p_legacy_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !release_mode |-> trip_oe);
endmodule

// File: tb/tb_thermal_trip_ctrl.sv
module tb_thermal_trip_ctrl;
  localparam int CODE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic release_mode = 1'b0;
  logic us_tick = 1'b0;
  logic temp_valid = 1'b0;
  logic [CODE_W-1:0] temp_code = '0;
  logic temp_ready, trip_n, trip_oe, halt_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thermal_trip_ctrl #(.CODE_W(CODE_W), .TRIP_CODE(135), .EN_DELAY_US(10)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .release_mode(release_mode),
    .us_tick(us_tick), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_code(temp_code), .trip_n(trip_n), .trip_oe(trip_oe),
    .halt_req(halt_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic pg);
    @(negedge clk);
    rst_n = 1'b0; release_mode = m; pwr_ok = pg;
    temp_valid = 1'b0; us_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [CODE_W-1:0] c, input logic v);
    temp_code = c; temp_valid = v;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1; @(negedge clk);
      us_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b0);
    chk("R1 legacy trip_n", trip_n, 1); chk("R1 legacy halt", halt_req, 0);
    chk("R1 legacy oe", trip_oe, 1);    chk("R10 ready", temp_ready, 1);
    do_reset(1'b1, 1'b0);
    chk("R1 window trip_n", trip_n, 1); chk("R1 window halt", halt_req, 0);
    chk("R1 window oe", trip_oe, 0);
  endtask

  task automatic t_legacy_trip();
    do_reset(1'b0, 1'b0);
    chk("R6 oe without pwr_ok", trip_oe, 1);
    send(8'd134, 1'b1);
    chk("R3 below threshold", halt_req, 0);
    send(8'd200, 1'b0);
    chk("R3 invalid beat ignored", trip_n, 1);
    send(8'd135, 1'b1);
    chk("R2 trip_n at threshold", trip_n, 0); chk("R2 halt", halt_req, 1);
    send(8'd20, 1'b1);
    chk("R4 cool code holds", trip_n, 0);
    pwr_ok = 1'b1; @(negedge clk); pwr_ok = 1'b0; @(negedge clk);
    chk("R6 pwr_ok ignored trip_n", trip_n, 0); chk("R6 pwr_ok ignored oe", trip_oe, 1);
  endtask

  task automatic t_legacy_reset();
    do_reset(1'b0, 1'b0);
    chk("R5 reset clears", halt_req, 0);
    send(8'd140, 1'b1);
    chk("R5 re-trip after reset", trip_n, 0);
  endtask

  task automatic t_window_delay_pretrip();
    do_reset(1'b1, 1'b0);
    pwr_ok = 1'b1; @(negedge clk);
    ticks(3);
    send(8'd160, 1'b1);
    chk("R9 halt before window", halt_req, 1);
    chk("R9 pin idle before window", trip_n, 1);
    ticks(6);
    chk("R7 oe closed after 9 ticks", trip_oe, 0);
    ticks(1);
    chk("R7 oe open after 10 ticks", trip_oe, 1);
    chk("R9 pin low once open", trip_n, 0);
  endtask

  task automatic t_window_release();
    pwr_ok = 1'b0; #1;
    chk("R8 oe drops same cycle", trip_oe, 0);
    chk("R8 pin idle same cycle", trip_n, 1);
    @(negedge clk);
    chk("R8 latch cleared", halt_req, 0);
    pwr_ok = 1'b1; @(negedge clk);
    ticks(9);
    us_tick = 1'b1; temp_code = 8'd170; temp_valid = 1'b1;
    @(negedge clk);
    us_tick = 1'b0; temp_valid = 1'b0;
    chk("R7 window opens with hot code", trip_oe, 1);
    chk("R2 re-trip same edge", trip_n, 0);
  endtask

  task automatic t_window_collision();
    temp_code = 8'd180; temp_valid = 1'b1; pwr_ok = 1'b0;
    @(negedge clk);
    temp_valid = 1'b0;
    chk("R12 hot during drop not latched", halt_req, 0);
    pwr_ok = 1'b1; @(negedge clk);
    chk("R12 nothing after return", halt_req, 0);
    send(8'd136, 1'b1);
    chk("R2 trip after return", halt_req, 1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 reset clears window trip", halt_req, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R11 stays clear", halt_req, 0);
  endtask

  initial begin
    t_reset_state();
    t_legacy_trip();
    t_legacy_reset();
    t_window_delay_pretrip();
    t_window_release();
    t_window_collision();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule